// File: doc/BRIEF.md
# Inter-Processor Interrupt Destination Mask Generator

This block turns one inter-processor interrupt command into the set of interrupt agents that must receive it. The command is written as two 32-bit words. The high word supplies the destination byte and is only stored. A write of the low word starts one evaluation. Each of up to `N_AGENTS` agents reports its physical ID, its 8-bit logical destination value, a 4-bit destination-format code and a present flag. From these and the sender's own index, the block selects the targets in one of three ways: by physical ID or broadcast, by flat or cluster logical matching, or by one of the destination shorthands.

The delivery mode then shapes the result. Lowest-priority delivery narrows the set to a single agent. A reserved mode delivers nothing. An INIT level-deassert command delivers nothing and instead loads each targeted agent's arbitration ID with that agent's physical ID. The block registers the target mask, the index of the first target and all decoded command fields. It presents them with a one-cycle valid pulse so that a downstream delivery fabric can act on them.

Top module: `ipi_dest_mask_gen`

## Requirements
- R1: Low-word fields are decoded as follows: vector [7:0], delivery mode [10:8], logical-destination flag bit 11, level bit 14, trigger bit 15, shorthand [19:18]. The destination is high-word bits [31:24]. Each field appears unchanged on its result port.
- R2: A low-word write produces exactly one `res_valid` pulse in the cycle after the write edge, carrying results registered at that edge. A high-word write only stores the destination byte, which later low-word writes use, and it raises no valid pulse.
- R3: Shorthand 1 targets only the agent at `sender_idx`. Shorthand 2 targets every agent. Shorthand 3 targets every agent except the sender. Shorthand 0 uses the destination field.
- R4: In physical mode (bit 11 = 0), destination 0xFF targets every agent. Any other value targets the lowest-indexed present agent whose physical ID equals it, or no agent if none does.
- R5: In logical mode, an agent with format 4'hF is targeted when the destination AND its logical value is nonzero.
- R6: In logical mode, an agent with format 4'h0 is targeted when the upper nibbles are equal and the AND of the lower nibbles is nonzero. An agent with any other format code is never targeted in logical mode.
- R7: Delivery mode 1 (lowest priority) targets only the lowest-indexed agent of the selected set. `res_sel_idx` gives the lowest set bit of `res_target` and `res_sel_found` flags a non-empty target. When the target is empty, the index reads 0.
- R8: Delivery mode 5 with level 0 and trigger 1 sets `res_deassert`, gives an empty target and copies each selected agent's physical ID into its `arb_id` slot. No other command changes `arb_id`.
- R9: An agent whose present flag is low is never targeted, even by broadcast or a shorthand.
- R10: Delivery mode 3 (reserved) gives an empty target.
- R11: After reset, `res_valid`, `res_target` and all `arb_id` slots are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_lo_we | input | 1 | Low command word write; starts an evaluation |
| cmd_hi_we | input | 1 | High command word write; stores the destination |
| cmd_wdata | input | 32 | Command write data |
| sender_idx | input | IDX_W | Index of the agent issuing the command |
| agent_present | input | N_AGENTS | Per-agent present flag |
| agent_phys_id | input | N_AGENTS*8 | Per-agent physical ID, agent g in [g*8+7:g*8] |
| agent_logical | input | N_AGENTS*8 | Per-agent logical destination value |
| agent_format | input | N_AGENTS*4 | Per-agent destination-format code |
| res_valid | output | 1 | One-cycle result strobe |
| res_target | output | N_AGENTS | Delivery target mask |
| res_vector | output | 8 | Decoded vector |
| res_mode | output | 3 | Decoded delivery mode |
| res_logical | output | 1 | Decoded logical-destination flag |
| res_level | output | 1 | Decoded level bit |
| res_trigger | output | 1 | Decoded trigger bit |
| res_shorthand | output | 2 | Decoded shorthand |
| res_dest | output | 8 | Destination byte used |
| res_deassert | output | 1 | Command was an INIT level-deassert |
| res_sel_idx | output | IDX_W | Lowest-indexed target |
| res_sel_found | output | 1 | Target mask non-empty |
| arb_id | output | N_AGENTS*8 | Per-agent arbitration ID |

## Verification
The assertions assume that the two write strobes are never raised in the same cycle. They also assume that the agent configuration inputs are the values meant at the low-word write edge, because the target checks compare against the present flags sampled one cycle earlier. The stimulus drives each strobe alone, one cycle after a clock edge, and keeps the agent table constant while commands are in flight. It also includes a back-to-back pair of low-word writes, which exercises consecutive valid pulses without overlapping writes.

// File: rtl/ipi_mask_pkg.sv
package ipi_mask_pkg;

   localparam int AGENT_ID_W = 8;
   localparam int AGENT_FMT_W = 4;

   typedef enum logic [2:0] {
      DM_FIXED   = 3'd0,
      DM_LOWEST  = 3'd1,
      DM_SMI     = 3'd2,
      DM_RSVD    = 3'd3,
      DM_NMI     = 3'd4,
      DM_INIT    = 3'd5,
      DM_STARTUP = 3'd6,
      DM_EXTINT  = 3'd7
   } dlv_mode_e;

   typedef enum logic [1:0] {
      SH_FIELD  = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } short_e;

   typedef struct packed {
      logic [AGENT_ID_W-1:0] dest;
      short_e                shorthand;
      logic                  trigger;
      logic                  level;
      logic                  logical;
      dlv_mode_e             mode;
      logic [7:0]            vector;
   } ipi_cmd_t;

   localparam logic [AGENT_ID_W-1:0]  DEST_BCAST  = 8'hFF;
   localparam logic [AGENT_FMT_W-1:0] FMT_FLAT    = 4'hF;
   localparam logic [AGENT_FMT_W-1:0] FMT_CLUSTER = 4'h0;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
   import ipi_mask_pkg::*;
(
   input  logic [31:0]           lo_word,
   input  logic [AGENT_ID_W-1:0] hi_dest,
   output ipi_cmd_t              cmd
);

   logic unused_lo_bits;
   assign unused_lo_bits = ^{lo_word[31:20], lo_word[17:16], lo_word[13:12]};

   always_comb begin
      cmd.vector    = lo_word[7:0];
      cmd.mode      = dlv_mode_e'(lo_word[10:8]);
      cmd.logical   = lo_word[11];
      cmd.level     = lo_word[14];
      cmd.trigger   = lo_word[15];
      cmd.shorthand = short_e'(lo_word[19:18]);
      cmd.dest      = hi_dest;
   end

endmodule

// File: rtl/ipi_lowest_pick.sv
module ipi_lowest_pick #(
   parameter int N_REQ   = 8,
   parameter int IDX_W   = 3,
   parameter bit ISOLATE = 1'b1
) (
   input  logic [N_REQ-1:0] req,
   output logic [N_REQ-1:0] grant,
   output logic [IDX_W-1:0] grant_idx,
   output logic             found
);

   localparam logic [N_REQ-1:0] ONE = {{(N_REQ-1){1'b0}}, 1'b1};

   generate
      if (ISOLATE) begin : g_isolate
         assign grant = req & (~req + ONE);
      end else begin : g_scan
         always_comb begin
            logic seen;
            seen = 1'b0;
            for (int i = 0; i < N_REQ; i++) begin
               grant[i] = req[i] & ~seen;
               seen     = seen | req[i];
            end
         end
      end
   endgenerate

   always_comb begin
      grant_idx = '0;
      for (int i = 0; i < N_REQ; i++) begin
         if (grant[i]) grant_idx = grant_idx | IDX_W'(i);
      end
   end

   assign found = |req;

   always_comb begin
      assert_grant_single_R7: assert ($onehot0(grant));
   end

endmodule

// File: rtl/ipi_agent_match.sv
module ipi_agent_match
   import ipi_mask_pkg::*;
#(
   parameter int N_AGENTS     = 8,
   parameter int IDX_W        = 3,
   parameter bit PICK_ISOLATE = 1'b1
) (
   input  ipi_cmd_t                         cmd,
   input  logic [IDX_W-1:0]                 sender_idx,
   input  logic [N_AGENTS-1:0]              present,
   input  logic [N_AGENTS*AGENT_ID_W-1:0]   phys_ids,
   input  logic [N_AGENTS*AGENT_ID_W-1:0]   logical_ids,
   input  logic [N_AGENTS*AGENT_FMT_W-1:0]  formats,
   output logic [N_AGENTS-1:0]              dest_mask
);

   function automatic logic logical_match(input logic [AGENT_ID_W-1:0]  dst,
                                          input logic [AGENT_ID_W-1:0]  lid,
                                          input logic [AGENT_FMT_W-1:0] fmt);
      logic hit;
      if (fmt == FMT_FLAT)
         hit = |(dst & lid);
      else if (fmt == FMT_CLUSTER)
         hit = (dst[7:4] == lid[7:4]) && (|(dst[3:0] & lid[3:0]));
      else
         hit = 1'b0;
      return hit;
   endfunction

   logic [N_AGENTS-1:0] id_hit;
   logic [N_AGENTS-1:0] log_hit;
   logic [N_AGENTS-1:0] self_bit;
   logic [N_AGENTS-1:0] phys_pick;
   logic [N_AGENTS-1:0] field_mask;
   logic [N_AGENTS-1:0] sh_mask;
   logic [IDX_W-1:0]    unused_pick_idx;
   logic                unused_pick_found;

   genvar g;
   generate
      for (g = 0; g < N_AGENTS; g++) begin : g_agent
         assign id_hit[g]   = present[g] &&
                              (phys_ids[g*AGENT_ID_W +: AGENT_ID_W] == cmd.dest);
         assign log_hit[g]  = logical_match(cmd.dest,
                                            logical_ids[g*AGENT_ID_W +: AGENT_ID_W],
                                            formats[g*AGENT_FMT_W +: AGENT_FMT_W]);
         assign self_bit[g] = (sender_idx == IDX_W'(g));
      end
   endgenerate

   ipi_lowest_pick #(
      .N_REQ   (N_AGENTS),
      .IDX_W   (IDX_W),
      .ISOLATE (PICK_ISOLATE)
   ) u_id_pick (
      .req       (id_hit),
      .grant     (phys_pick),
      .grant_idx (unused_pick_idx),
      .found     (unused_pick_found)
   );

   always_comb begin
      if (cmd.logical)
         field_mask = log_hit;
      else if (cmd.dest == DEST_BCAST)
         field_mask = '1;
      else
         field_mask = phys_pick;

      unique case (cmd.shorthand)
         SH_FIELD:  sh_mask = field_mask;
         SH_SELF:   sh_mask = self_bit;
         SH_ALL:    sh_mask = '1;
         SH_OTHERS: sh_mask = ~self_bit;
         default:   sh_mask = '0;
      endcase

      dest_mask = sh_mask & present;
   end

   always_comb begin
      assert_phys_single_R4: assert (cmd.logical || cmd.dest == DEST_BCAST ||
                                     cmd.shorthand != SH_FIELD || $onehot0(dest_mask));
   end

endmodule

// File: rtl/ipi_dest_mask_gen.sv
module ipi_dest_mask_gen
   import ipi_mask_pkg::*;
#(
   parameter int N_AGENTS     = 8,
   parameter int IDX_W        = $clog2(N_AGENTS),
   parameter bit PICK_ISOLATE = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cmd_lo_we,
   input  logic                        cmd_hi_we,
   input  logic [31:0]                 cmd_wdata,
   input  logic [IDX_W-1:0]            sender_idx,
   input  logic [N_AGENTS-1:0]         agent_present,
   input  logic [N_AGENTS*8-1:0]       agent_phys_id,
   input  logic [N_AGENTS*8-1:0]       agent_logical,
   input  logic [N_AGENTS*4-1:0]       agent_format,
   output logic                        res_valid,
   output logic [N_AGENTS-1:0]         res_target,
   output logic [7:0]                  res_vector,
   output logic [2:0]                  res_mode,
   output logic                        res_logical,
   output logic                        res_level,
   output logic                        res_trigger,
   output logic [1:0]                  res_shorthand,
   output logic [7:0]                  res_dest,
   output logic                        res_deassert,
   output logic [IDX_W-1:0]            res_sel_idx,
   output logic                        res_sel_found,
   output logic [N_AGENTS*8-1:0]       arb_id
);

   localparam int ARB_W = N_AGENTS * AGENT_ID_W;

   generate
      if (N_AGENTS < 2 || N_AGENTS > 256) begin : g_bad_count
         $error("ipi_dest_mask_gen: N_AGENTS must lie in 2..256");
      end
      if (IDX_W != $clog2(N_AGENTS)) begin : g_bad_idx
         $error("ipi_dest_mask_gen: IDX_W must equal clog2(N_AGENTS)");
      end
   endgenerate

   logic [AGENT_ID_W-1:0] hi_dest_q;
   ipi_cmd_t              cmd;
   logic [N_AGENTS-1:0]   dest_mask;
   logic [N_AGENTS-1:0]   first_grant;
   logic [IDX_W-1:0]      first_idx;
   logic                  unused_first_found;
   logic                  deassert_d;
   logic [N_AGENTS-1:0]   target_d;
   logic [ARB_W-1:0]      arb_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         hi_dest_q <= '0;
      else if (cmd_hi_we)
         hi_dest_q <= cmd_wdata[31:24];
   end

   ipi_cmd_decode u_decode (
      .lo_word (cmd_wdata),
      .hi_dest (hi_dest_q),
      .cmd     (cmd)
   );

   ipi_agent_match #(
      .N_AGENTS     (N_AGENTS),
      .IDX_W        (IDX_W),
      .PICK_ISOLATE (PICK_ISOLATE)
   ) u_match (
      .cmd         (cmd),
      .sender_idx  (sender_idx),
      .present     (agent_present),
      .phys_ids    (agent_phys_id),
      .logical_ids (agent_logical),
      .formats     (agent_format),
      .dest_mask   (dest_mask)
   );

   ipi_lowest_pick #(
      .N_REQ   (N_AGENTS),
      .IDX_W   (IDX_W),
      .ISOLATE (PICK_ISOLATE)
   ) u_first (
      .req       (dest_mask),
      .grant     (first_grant),
      .grant_idx (first_idx),
      .found     (unused_first_found)
   );

   assign deassert_d = (cmd.mode == DM_INIT) && !cmd.level && cmd.trigger;

   always_comb begin
      if (deassert_d)
         target_d = '0;
      else if (cmd.mode == DM_RSVD)
         target_d = '0;
      else if (cmd.mode == DM_LOWEST)
         target_d = first_grant;
      else
         target_d = dest_mask;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid     <= 1'b0;
         res_target    <= '0;
         res_vector    <= '0;
         res_mode      <= '0;
         res_logical   <= 1'b0;
         res_level     <= 1'b0;
         res_trigger   <= 1'b0;
         res_shorthand <= '0;
         res_dest      <= '0;
         res_deassert  <= 1'b0;
         res_sel_idx   <= '0;
         res_sel_found <= 1'b0;
      end else begin
         res_valid <= cmd_lo_we;
         if (cmd_lo_we) begin
            res_target    <= target_d;
            res_vector    <= cmd.vector;
            res_mode      <= cmd.mode;
            res_logical   <= cmd.logical;
            res_level     <= cmd.level;
            res_trigger   <= cmd.trigger;
            res_shorthand <= cmd.shorthand;
            res_dest      <= cmd.dest;
            res_deassert  <= deassert_d;
            res_sel_idx   <= (|target_d) ? first_idx : '0;
            res_sel_found <= |target_d;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arb_q <= '0;
      end else if (cmd_lo_we && deassert_d) begin
         for (int i = 0; i < N_AGENTS; i++) begin
            if (dest_mask[i])
               arb_q[i*AGENT_ID_W +: AGENT_ID_W] <= agent_phys_id[i*AGENT_ID_W +: AGENT_ID_W];
         end
      end
   end

   assign arb_id = arb_q;

   assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_lo_we && cmd_hi_we));

   assert_valid_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(cmd_lo_we));

   assert_lowest_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_mode == DM_LOWEST) |-> $onehot0(res_target));

   assert_deassert_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_deassert) |-> (res_target == '0));

   assert_arb_only_deassert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(arb_id) |-> (res_valid && res_deassert));

   assert_present_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> ((res_target & ~$past(agent_present)) == '0));

   assert_rsvd_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_mode == DM_RSVD) |-> (res_target == '0));

   assert_found_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_sel_found == (res_target != '0)));

endmodule

// File: tb/ipi_dest_mask_gen_tb.sv
module ipi_dest_mask_gen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int N = 8;
   localparam int IW = 3;

   typedef struct {
      logic [N-1:0]   target;
      logic [7:0]     vec;
      logic [2:0]     mode;
      logic           lmode;
      logic           lvl;
      logic           trig;
      logic [1:0]     sh;
      logic [7:0]     dest;
      logic           deassert;
      logic [IW-1:0]  sel;
      logic           found;
      logic [N*8-1:0] arb;
      string          tag;
   } exp_t;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cmd_lo_we = 1'b0;
   logic           cmd_hi_we = 1'b0;
   logic [31:0]    cmd_wdata = '0;
   logic [IW-1:0]  sender_idx = '0;
   logic [N-1:0]   agent_present = '0;
   logic [N*8-1:0] agent_phys_id;
   logic [N*8-1:0] agent_logical;
   logic [N*4-1:0] agent_format;
   logic           res_valid;
   logic [N-1:0]   res_target;
   logic [7:0]     res_vector;
   logic [2:0]     res_mode;
   logic           res_logical;
   logic           res_level;
   logic           res_trigger;
   logic [1:0]     res_shorthand;
   logic [7:0]     res_dest;
   logic           res_deassert;
   logic [IW-1:0]  res_sel_idx;
   logic           res_sel_found;
   logic [N*8-1:0] arb_id;

   logic [7:0] cfg_phys [N];
   logic [7:0] cfg_log  [N];
   logic [3:0] cfg_fmt  [N];
   logic [7:0] arb_m    [N];
   logic [7:0] hi_m;

   exp_t q[$];
   int checks = 0;
   int fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   always_comb begin
      for (int i = 0; i < N; i++) begin
         agent_phys_id[i*8 +: 8] = cfg_phys[i];
         agent_logical[i*8 +: 8] = cfg_log[i];
         agent_format[i*4 +: 4]  = cfg_fmt[i];
      end
   end

   ipi_dest_mask_gen #(.N_AGENTS(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_lo_we(cmd_lo_we), .cmd_hi_we(cmd_hi_we),
      .cmd_wdata(cmd_wdata), .sender_idx(sender_idx), .agent_present(agent_present),
      .agent_phys_id(agent_phys_id), .agent_logical(agent_logical),
      .agent_format(agent_format), .res_valid(res_valid), .res_target(res_target),
      .res_vector(res_vector), .res_mode(res_mode), .res_logical(res_logical),
      .res_level(res_level), .res_trigger(res_trigger), .res_shorthand(res_shorthand),
      .res_dest(res_dest), .res_deassert(res_deassert), .res_sel_idx(res_sel_idx),
      .res_sel_found(res_sel_found), .arb_id(arb_id));

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_lo(input logic [7:0] vec, input logic [2:0] mode,
                                         input logic lmode, input logic lvl,
                                         input logic trig, input logic [1:0] sh);
      logic [31:0] w;
      w = '0;
      w[7:0] = vec; w[10:8] = mode; w[11] = lmode;
      w[14] = lvl; w[15] = trig; w[19:18] = sh;
      return w;
   endfunction

   // Reference built from the requirement text, not from the RTL structure.
   function automatic exp_t model(input logic [31:0] lo, input logic [7:0] dst,
                                  input logic [IW-1:0] snd, input string tag);
      exp_t e;
      logic [N-1:0] sel;
      bit got;
      e.vec = lo[7:0]; e.mode = lo[10:8]; e.lmode = lo[11];
      e.lvl = lo[14]; e.trig = lo[15]; e.sh = lo[19:18]; e.dest = dst;
      e.tag = tag;
      sel = '0;
      case (e.sh)
         2'd1: sel[snd] = 1'b1;
         2'd2: sel = '1;
         2'd3: begin sel = '1; sel[snd] = 1'b0; end
         default: begin
            if (e.lmode) begin
               for (int i = 0; i < N; i++) begin
                  if (cfg_fmt[i] == 4'hF && (dst & cfg_log[i]) != 0) sel[i] = 1'b1;
                  if (cfg_fmt[i] == 4'h0 && dst[7:4] == cfg_log[i][7:4] &&
                      (dst[3:0] & cfg_log[i][3:0]) != 0) sel[i] = 1'b1;
               end
            end else if (dst == 8'hFF) begin
               sel = '1;
            end else begin
               got = 0;
               for (int i = 0; i < N; i++)
                  if (!got && agent_present[i] && cfg_phys[i] == dst) begin
                     sel[i] = 1'b1; got = 1;
                  end
            end
         end
      endcase
      sel = sel & agent_present;
      e.deassert = (e.mode == 3'd5) && !e.lvl && e.trig;
      if (e.deassert) begin
         for (int i = 0; i < N; i++) if (sel[i]) arb_m[i] = cfg_phys[i];
         e.target = '0;
      end else if (e.mode == 3'd3) e.target = '0;
      else if (e.mode == 3'd1) begin
         e.target = '0; got = 0;
         for (int i = 0; i < N; i++) if (!got && sel[i]) begin e.target[i] = 1'b1; got = 1; end
      end else e.target = sel;
      e.sel = '0; e.found = (e.target != 0); got = 0;
      for (int i = 0; i < N; i++) if (!got && e.target[i]) begin e.sel = IW'(i); got = 1; end
      for (int i = 0; i < N; i++) e.arb[i*8 +: 8] = arb_m[i];
      return e;
   endfunction

   task automatic write_hi(input logic [7:0] dst);
      @(posedge clk); #1;
      cmd_hi_we = 1'b1; cmd_wdata = {dst, 24'h5A5A5A};
      hi_m = dst;
      @(posedge clk); #1;
      cmd_hi_we = 1'b0;
   endtask

   task automatic send_lo(input logic [31:0] lo, input logic [IW-1:0] snd, input string tag);
      @(posedge clk); #1;
      cmd_lo_we = 1'b1; cmd_wdata = lo; sender_idx = snd;
      q.push_back(model(lo, hi_m, snd, tag));
      @(posedge clk); #1;
      cmd_lo_we = 1'b0;
   endtask

   task automatic send(input logic [7:0] dst, input logic [31:0] lo,
                       input logic [IW-1:0] snd, input string tag);
      write_hi(dst);
      send_lo(lo, snd, tag);
      repeat (2) @(posedge clk);
   endtask

   // Monitor: pop the scoreboard on each result strobe.
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         if (q.size() == 0) begin
            chk(1'b0, "R2 unexpected valid", 64'(res_valid), 64'd0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(res_target == e.target, e.tag, 64'(res_target), 64'(e.target));
            chk({res_vector, res_mode, res_logical, res_level, res_trigger, res_shorthand, res_dest}
                == {e.vec, e.mode, e.lmode, e.lvl, e.trig, e.sh, e.dest},
                "R1 fields",
                64'({res_vector, res_mode, res_logical, res_level, res_trigger, res_shorthand, res_dest}),
                64'({e.vec, e.mode, e.lmode, e.lvl, e.trig, e.sh, e.dest}));
            chk(res_deassert == e.deassert && arb_id == e.arb, "R8 deassert/arb",
                64'(arb_id), 64'(e.arb));
            chk(res_sel_idx == e.sel && res_sel_found == e.found, "R7 select",
                64'({res_sel_found, res_sel_idx}), 64'({e.found, e.sel}));
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      chk(1'b0, "R2 watchdog expired", 64'd0, 64'd1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      hi_m = '0;
      for (int i = 0; i < N; i++) begin
         arb_m[i] = '0;
         cfg_phys[i] = 8'h20 + 8'(i);
         if (i < 4) begin cfg_fmt[i] = 4'hF; cfg_log[i] = 8'(1 << i); end
         else begin cfg_fmt[i] = 4'h0; cfg_log[i] = {4'h2, 4'(1 << (i - 4))}; end
      end
      cfg_phys[6] = 8'h23;
      cfg_fmt[3]  = 4'h8;
      cfg_log[7]  = 8'h21;
      agent_present = 8'b0111_1111;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(res_valid == 1'b0 && res_target == '0, "R11 reset outputs",
          64'({res_valid, res_target}), 64'd0);
      chk(arb_id == '0, "R11 reset arb", 64'(arb_id), 64'd0);

      // R2: high word alone raises no valid, but is kept for the next low write
      write_hi(8'h24);
      repeat (3) @(negedge clk);
      chk(res_valid == 1'b0 && q.size() == 0, "R2 high write only", 64'(res_valid), 64'd0);
      send_lo(mk_lo(8'h41, 3'd0, 0, 1, 0, 2'd0), 0, "R2 stored dest");
      repeat (2) @(posedge clk);

      send(8'hFF, mk_lo(8'h31, 3'd0, 0, 1, 0, 2'd0), 0, "R4 R9 broadcast");
      send(8'h22, mk_lo(8'h32, 3'd4, 0, 1, 0, 2'd0), 0, "R4 id match");
      send(8'h23, mk_lo(8'h33, 3'd2, 0, 1, 1, 2'd0), 0, "R4 duplicate id lowest");
      send(8'h27, mk_lo(8'h34, 3'd0, 0, 1, 0, 2'd0), 0, "R9 absent id");
      send(8'h55, mk_lo(8'h35, 3'd0, 0, 1, 0, 2'd0), 0, "R4 no match");
      send(8'h05, mk_lo(8'h36, 3'd0, 1, 1, 0, 2'd0), 0, "R5 flat");
      send(8'h08, mk_lo(8'h37, 3'd0, 1, 1, 0, 2'd0), 0, "R6 other format");
      send(8'h23, mk_lo(8'h38, 3'd0, 1, 1, 0, 2'd0), 0, "R6 cluster");
      send(8'h21, mk_lo(8'h39, 3'd0, 1, 1, 0, 2'd0), 0, "R6 R9 cluster absent");
      send(8'h33, mk_lo(8'h3A, 3'd0, 1, 1, 0, 2'd0), 0, "R5 R6 mixed");
      send(8'hFF, mk_lo(8'h40, 3'd0, 0, 1, 0, 2'd1), 4, "R3 self");
      send(8'h00, mk_lo(8'h41, 3'd0, 0, 1, 0, 2'd2), 2, "R3 all");
      send(8'h00, mk_lo(8'h42, 3'd0, 0, 1, 0, 2'd3), 0, "R3 others");
      send(8'h00, mk_lo(8'h43, 3'd0, 0, 1, 0, 2'd1), 7, "R9 R3 self absent");
      send(8'h06, mk_lo(8'h50, 3'd1, 1, 1, 0, 2'd0), 0, "R7 lowest logical");
      send(8'h00, mk_lo(8'h51, 3'd1, 0, 1, 0, 2'd3), 0, "R7 lowest others");
      send(8'hFF, mk_lo(8'h52, 3'd3, 0, 1, 0, 2'd0), 0, "R10 reserved");
      send(8'h21, mk_lo(8'h00, 3'd5, 0, 0, 1, 2'd0), 0, "R8 deassert one");
      send(8'hFF, mk_lo(8'h00, 3'd5, 0, 1, 1, 2'd0), 0, "R8 init asserted");
      send(8'h00, mk_lo(8'h00, 3'd5, 0, 0, 1, 2'd2), 3, "R8 deassert all");
      send(8'h30, mk_lo(8'h9A, 3'd6, 1, 0, 1, 2'd0), 0, "R1 startup fields");

      // R2 back-to-back low writes give two consecutive strobes
      @(posedge clk); #1;
      cmd_lo_we = 1'b1; cmd_wdata = mk_lo(8'hC1, 3'd7, 0, 1, 0, 2'd2); sender_idx = 1;
      q.push_back(model(cmd_wdata, hi_m, 1, "R2 burst first"));
      @(posedge clk); #1;
      cmd_wdata = mk_lo(8'hC2, 3'd0, 0, 1, 0, 2'd1); sender_idx = 5;
      q.push_back(model(cmd_wdata, hi_m, 5, "R2 burst second"));
      @(posedge clk); #1;
      cmd_lo_we = 1'b0;
      repeat (4) @(negedge clk);
      chk(q.size() == 0, "R2 all results seen", 64'(q.size()), 64'd0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule